// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a serial-output analog-to-digital converter whose data pin carries one conversion result per chip-select frame. A frame begins when the block pulls its active-low select low. That edge also starts the conversion in the converter. The block then toggles a serial clock derived from the system clock by a fixed divider and samples the data pin at every falling edge of that clock. Each frame opens with four zero bits. The conversion word follows, most significant bit first, and the tail may be padded with zeros. The block drops the padding and presents the word right-aligned and zero-extended in a 12-bit result, together with a one-cycle valid strobe.

A frame can be started by a single-cycle request or by an internal pacing timer that fires at a fixed interval. The frame length comes from a mode input sampled at frame start. It is either the shortest count that completes a conversion (resolution plus four clocks) or a full sixteen clocks. The converter resolution (8, 10 or 12) is a parameter. The host can end a frame early. If it does so before the shortest count has been reached, the conversion is lost: the block raises an abort flag and holds its previous result. After every frame, the select stays high for a programmable quiet period, and requests that arrive during it are dropped.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, csN and sclk are high, resultValid and frameAborted are low, and result is zero.
- R2: Once a frame starts, sclk stays high for CLK_DIV system cycles after csN falls. It then alternates low and high, each half lasting CLK_DIV cycles. The first falling edge therefore comes CLK_DIV cycles after csN falls, and each later falling edge follows the previous one by 2*CLK_DIV cycles.
- R3: With fullFrame low, a frame has exactly RES_BITS+4 falling edges of sclk. With fullFrame high, it has 16. fullFrame is sampled only in the cycle the frame starts, so changing it mid-frame has no effect.
- R4: The block samples sdata as it drives each sclk falling edge. The first four samples are discarded. The next RES_BITS samples form the word, most significant bit first. Any later samples are ignored.
- R5: The result appears zero-extended in the 12-bit result output. resultValid pulses high for one cycle, in the cycle after csN rises.
- R6: abortReq during a frame with fewer than RES_BITS+4 falling edges raises csN in the next cycle. frameAborted then pulses for one cycle, resultValid stays low, and result keeps its previous value.
- R7: abortReq in a full-length frame after RES_BITS+4 falling edges ends the frame early, but the conversion word is still delivered with resultValid.
- R8: After a frame, csN stays high for quietLen+1 quiet cycles and then one idle cycle. A request that arrives during the quiet period is dropped, not queued. A request held high continuously starts the next frame exactly quietLen+2 cycles after csN rose.
- R9: While autoEn is high, the pacing timer fires every AUTO_PERIOD cycles, counting from the cycle autoEn rises. A firing that finds the block idle starts a frame, so back-to-back paced frames are AUTO_PERIOD cycles apart.
- R10: resultValid and frameAborted are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Frame request, honoured only when idle |
| autoEn | input | 1 | Enables the pacing timer |
| fullFrame | input | 1 | 1: 16-clock frame, 0: shortest complete frame |
| abortReq | input | 1 | Ends the current frame at once |
| quietLen | input | QUIET_W | Quiet cycles (minus one) after each frame |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle high |
| result | output | 12 | Right-aligned, zero-extended conversion word |
| resultValid | output | 1 | One-cycle strobe for a completed frame |
| frameAborted | output | 1 | One-cycle strobe for a lost conversion |

## Verification
The embedded properties check several rules on every cycle. Each high phase of sclk lasts at least CLK_DIV cycles. The falling-edge count never exceeds sixteen. csN stays high for at least two cycles once it rises. The two output strobes are single-cycle and mutually exclusive, and an abort leaves the result untouched. Other behaviour can only be shown through the bench scenarios. These include the exact edge count for each frame mode, which bits of the serial stream land in the result, where the boundary lies between a lost conversion and an early but complete one, dropped requests during the quiet period, and the spacing of paced frames.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  localparam int LEAD_BITS  = 4;
  localparam int FULL_CLKS  = 16;
  localparam int OUT_W      = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_QUIET
  } rd_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // new frame: empty the shift register
    logic shift;   // take one data bit
    logic done;    // publish the word
    logic abort;   // conversion lost
  } rd_strobe_t;

endpackage

// File: rtl/adcrd_pacer.sv
module adcrd_pacer #(
  parameter int AUTO_PERIOD = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic autoEn,
  output logic tick
);
  localparam int P_W = (AUTO_PERIOD > 2) ? $clog2(AUTO_PERIOD) : 1;
  localparam logic [P_W-1:0] P_LAST = P_W'(AUTO_PERIOD - 1);

  logic [P_W-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  periodCnt <= '0;
    else if (!autoEn)           periodCnt <= '0;
    else if (periodCnt == P_LAST) periodCnt <= '0;
    else                        periodCnt <= periodCnt + 1'b1;
  end

  assign tick = autoEn && (periodCnt == P_LAST);

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && AUTO_PERIOD > 1) |=> !tick);

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CLK_DIV  = 4,
  parameter int QUIET_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               tick,
  input  logic               fullFrame,
  input  logic               abortReq,
  input  logic [QUIET_W-1:0] quietLen,
  output logic               csN,
  output logic               sclk,
  output rd_strobe_t         strobe
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HC_W  = $clog2(CLK_DIV + 1) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [4:0] MIN_CLKS  = 5'(RES_BITS + LEAD_BITS);
  localparam logic [4:0] FIRST_BIT = 5'(LEAD_BITS);
  localparam logic [4:0] FULL_C    = 5'(FULL_CLKS);

  rd_state_t          state;
  logic [DIV_W-1:0]   divCnt;
  logic [4:0]         fallCnt;
  logic               fullLat;
  logic [QUIET_W-1:0] quietCnt;

  logic halfDone, active, startNow, fallNow, lastFall;
  logic [4:0] frameLen;

  assign halfDone = (divCnt == DIV_LAST);
  assign active   = (state == ST_SETUP) || (state == ST_HIGH) || (state == ST_LOW);
  assign startNow = (state == ST_IDLE) && (startReq || tick);
  assign frameLen = fullLat ? FULL_C : MIN_CLKS;
  assign fallNow  = ((state == ST_SETUP) || (state == ST_HIGH)) && halfDone && !abortReq;
  assign lastFall = (state == ST_LOW) && halfDone && !abortReq && (fallCnt == frameLen);

  assign csN  = !active;
  assign sclk = (state != ST_LOW);

  always_comb begin
    strobe.clear = startNow;
    strobe.shift = fallNow && (fallCnt >= FIRST_BIT) && (fallCnt < MIN_CLKS);
    strobe.done  = lastFall || (active && abortReq && fallCnt >= MIN_CLKS);
    strobe.abort = active && abortReq && (fallCnt < MIN_CLKS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      fallCnt  <= '0;
      fullLat  <= 1'b0;
      quietCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startNow) begin
          state   <= ST_SETUP;
          divCnt  <= '0;
          fallCnt <= '0;
          fullLat <= fullFrame;
        end
        ST_SETUP, ST_HIGH: begin
          if (abortReq) begin
            state    <= ST_QUIET;
            quietCnt <= '0;
          end else if (halfDone) begin
            state   <= ST_LOW;
            divCnt  <= '0;
            fallCnt <= fallCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (abortReq || lastFall) begin
            state    <= ST_QUIET;
            quietCnt <= '0;
          end else if (halfDone) begin
            state  <= ST_HIGH;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_QUIET: begin
          if (quietCnt == quietLen) state <= ST_IDLE;
          else                      quietCnt <= quietCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker: length of each sclk high phase
  logic [HC_W-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          hiCnt <= '0;
    else if (!sclk)                     hiCnt <= '0;
    else if (hiCnt != HC_W'(CLK_DIV))   hiCnt <= hiCnt + 1'b1;
  end

  // R2
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclk && hiCnt != '0) |-> hiCnt >= HC_W'(CLK_DIV));

  // R3
  fall_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= FULL_C);

  // R8
  quiet_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);

  // R4
  shift_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> (!csN && sclk));

endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdata,
  input  rd_strobe_t       strobe,
  output logic [OUT_W-1:0] result,
  output logic             resultValid,
  output logic             frameAborted
);
  logic [RES_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg     <= '0;
      result       <= '0;
      resultValid  <= 1'b0;
      frameAborted <= 1'b0;
    end else begin
      resultValid  <= strobe.done;
      frameAborted <= strobe.abort;
      if (strobe.clear)      shiftReg <= '0;
      else if (strobe.shift) shiftReg <= {shiftReg[RES_BITS-2:0], sdata};
      if (strobe.done)       result   <= OUT_W'(shiftReg);
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && frameAborted));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAborted |-> $stable(result));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcrd_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int CLK_DIV     = 4,
  parameter int QUIET_W     = 8,
  parameter int AUTO_PERIOD = 300
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               autoEn,
  input  logic               fullFrame,
  input  logic               abortReq,
  input  logic [QUIET_W-1:0] quietLen,
  input  logic               sdata,
  output logic               csN,
  output logic               sclk,
  output logic [11:0]        result,
  output logic               resultValid,
  output logic               frameAborted
);
  rd_strobe_t strobe;
  logic       tick;

  adcrd_pacer #(.AUTO_PERIOD(AUTO_PERIOD)) pacer_i (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .tick(tick)
  );

  adcrd_ctrl #(.RES_BITS(RES_BITS), .CLK_DIV(CLK_DIV), .QUIET_W(QUIET_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tick(tick),
    .fullFrame(fullFrame), .abortReq(abortReq), .quietLen(quietLen),
    .csN(csN), .sclk(sclk), .strobe(strobe)
  );

  adcrd_datapath #(.RES_BITS(RES_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .sdata(sdata), .strobe(strobe),
    .result(result), .resultValid(resultValid), .frameAborted(frameAborted)
  );

endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int RES   = 10;
  localparam int DIV   = 4;
  localparam int QW    = 8;
  localparam int APER  = 300;
  localparam int MINC  = RES + 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, autoEn = 1'b0, fullFrame = 1'b0, abortReq = 1'b0;
  logic [QW-1:0] quietLen = 8'd10;
  logic sdata, csN, sclk, resultValid, frameAborted;
  logic [11:0] result;

  always #4 clk = ~clk;

  adc_frame_reader #(.RES_BITS(RES), .CLK_DIV(DIV), .QUIET_W(QW), .AUTO_PERIOD(APER)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .autoEn(autoEn),
    .fullFrame(fullFrame), .abortReq(abortReq), .quietLen(quietLen),
    .sdata(sdata), .csN(csN), .sclk(sclk), .result(result),
    .resultValid(resultValid), .frameAborted(frameAborted)
  );

  int nTests = 0, nFail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int  adcVals[$];
  logic [RES-1:0] word = '0;
  int  bitIdx = 0, fallsSeen = 0;
  bit  gapBad = 0;
  time csFallT = 0, lastFallT = 0;
  time csFalls[$];

  function automatic logic bitAt(input int i, input logic [RES-1:0] w);
    if (i < 4)          return 1'b0;
    else if (i < 4+RES) return w[RES-1-(i-4)];
    else if (i < 16)    return 1'b0;
    else                return 1'b1;
  endfunction

  assign sdata = csN ? 1'b1 : bitAt(bitIdx, word);

  always @(negedge csN or negedge sclk) begin
    if (sclk) begin
      word      = (adcVals.size() > 0) ? RES'(adcVals.pop_front()) : '0;
      bitIdx    = 0;
      fallsSeen = 0;
      csFallT   = $time;
      csFalls.push_back($time);
    end else if (!csN) begin
      if (fallsSeen == 0) begin
        if (($time - csFallT) / 8 != DIV) gapBad = 1;
      end else if (($time - lastFallT) / 8 != 2*DIV) gapBad = 1;
      lastFallT = $time;
      bitIdx++;
      fallsSeen++;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit isAbort; logic [11:0] val; string req; } exp_t;
  exp_t expQ[$];
  logic [11:0] lastGood = '0;

  always @(negedge clk) begin
    if (rstN && (resultValid || frameAborted)) begin
      if (resultValid && frameAborted)
        check(0, "R10", "both strobes high", 1, 0);
      if (expQ.size() == 0) begin
        check(0, "R5", "unexpected result", int'(result), 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(frameAborted == e.isAbort, e.req, "abort flag", int'(frameAborted), int'(e.isAbort));
        if (e.isAbort)
          check(result == lastGood, e.req, "result held after abort", int'(result), int'(lastGood));
        else begin
          check(result == e.val, e.req, "result word", int'(result), int'(e.val));
          lastGood = e.val;
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic runFrame(input int value, input bit full, input bit flipMid,
                          input int abortAfter, input bit expAbort, input string req);
    int expFalls;
    exp_t e;
    adcVals.push_back(value);
    e.isAbort = expAbort; e.val = 12'(value & ((1 << RES) - 1)); e.req = req;
    expQ.push_back(e);
    @(negedge clk); fullFrame = full; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    if (flipMid) fullFrame = !full;
    if (abortAfter >= 0) begin
      while (fallsSeen < abortAfter) @(negedge clk);
      repeat (2) @(negedge clk);
      abortReq = 1'b1;
      @(negedge clk); abortReq = 1'b0;
    end
    while (!csN) @(negedge clk);
    expFalls = (abortAfter >= 0) ? abortAfter : (full ? 16 : MINC);
    // R3
    check(fallsSeen == expFalls, "R3", "sclk falling edges", fallsSeen, expFalls);
    repeat (int'(quietLen) + 4) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // ---------------- scenarios ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 1'b1, "R1", "csN in reset", int'(csN), 1);
    check(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
    check(resultValid == 1'b0, "R1", "resultValid in reset", int'(resultValid), 0);
    check(frameAborted == 1'b0, "R1", "frameAborted in reset", int'(frameAborted), 0);
    check(result == 12'h0, "R1", "result in reset", int'(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5: data patterns, shortest frame
    runFrame('h2AA, 0, 0, -1, 0, "R4");
    check(gapBad == 0, "R2", "sclk edge spacing", int'(gapBad), 0);
    runFrame('h3FF, 1, 0, -1, 0, "R5");
    runFrame('h000, 0, 0, -1, 0, "R4");
    runFrame('h155, 1, 0, -1, 0, "R4");
    // R3: fullFrame flipped mid-frame has no effect
    runFrame('h0F3, 0, 1, -1, 0, "R3");
    check(gapBad == 0, "R2", "sclk edge spacing all frames", int'(gapBad), 0);

    // R6: early aborts
    runFrame('h1E1, 0, 0, 5, 1, "R6");
    runFrame('h2B4, 1, 0, 0, 1, "R6");
    runFrame('h0AB, 1, 0, MINC - 1, 1, "R6");
    // R7: abort after minimum count in a full frame still delivers
    runFrame('h1C3, 1, 0, MINC, 0, "R7");

    // R8: request during quiet is dropped
    quietLen = 8'd40;
    begin
      exp_t e;
      adcVals.push_back('h321);
      e.isAbort = 0; e.val = 12'h321; e.req = "R8"; expQ.push_back(e);
      @(negedge clk); fullFrame = 0; startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      while (!csN) @(negedge clk);
      startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      n = 0;
      repeat (80) begin
        @(negedge clk);
        if (!csN) n++;
      end
      check(n == 0, "R8", "cycles low after dropped request", n, 0);
    end

    // R8: exact quiet length with request held high
    quietLen = 8'd5;
    begin
      exp_t e;
      adcVals.push_back('h0C0); adcVals.push_back('h303);
      e.isAbort = 0; e.val = 12'h0C0; e.req = "R8"; expQ.push_back(e);
      e.val = 12'h303; expQ.push_back(e);
      @(negedge clk); startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      while (!csN) @(negedge clk);
      n = 1;
      startReq = 1'b1;
      forever begin
        @(negedge clk);
        if (csN) n++; else break;
      end
      startReq = 1'b0;
      check(n == int'(quietLen) + 2, "R8", "csN high cycles between frames", n, int'(quietLen) + 2);
      while (!csN) @(negedge clk);
      repeat (int'(quietLen) + 4) @(negedge clk);
    end

    // R9: paced frames
    quietLen = 8'd8;
    csFalls.delete();
    for (int k = 0; k < 3; k++) begin
      exp_t e;
      adcVals.push_back(100 + 37*k);
      e.isAbort = 0; e.val = 12'(100 + 37*k); e.req = "R9"; expQ.push_back(e);
    end
    @(negedge clk); autoEn = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    autoEn = 1'b0;
    check(csFalls.size() == 3, "R9", "paced frame count", csFalls.size(), 3);
    if (csFalls.size() == 3) begin
      check((csFalls[1] - csFalls[0]) / 8 == APER, "R9", "pacing gap 1",
            int'((csFalls[1] - csFalls[0]) / 8), APER);
      check((csFalls[2] - csFalls[1]) / 8 == APER, "R9", "pacing gap 2",
            int'((csFalls[2] - csFalls[1]) / 8), APER);
    end
    repeat (20) @(negedge clk);

    check(expQ.size() == 0, "R5", "outstanding results", expQ.size(), 0);
    finishRun();
  end

endmodule